// File: doc/BRIEF.md
# SPI Register-Window Slave

This block is a 16-bit SPI slave that gives an external master access to a bank of 16-bit registers on the fabric side. The master first sends a control word that chooses a mode (read only, or read with simultaneous write), a starting register offset and a word count. Every data word after that reads one register out on MISO. In read-write mode the same word transfer also writes the received MOSI word back into that register. The address steps through a window that starts at the offset and is as long as the word count, and it returns to the offset when the window ends.

A control-reset input re-arms the slave so that the next word is taken as a control word. The last control word stays in force across bursts until the slave is re-armed again. A global reset returns all SPI state to default. SCLK, MOSI and the control-reset input are asynchronous. They are synchronized into a much faster system clock, and the SCLK edges are detected there. The register bank itself sits outside the block: it supplies combinational read data for the read address and accepts a single-cycle write strobe.

Top module: `spi_regwin_slave`

## Requirements
- R1: After the global reset, MISO presents the identification word's MSB, the write strobe is low, and the next 16-bit word is taken as a control word, with no re-arm needed.
- R2: After a high-then-low pulse on the control-reset input, the next 16-bit word is captured as a control word. While that word is received, MISO returns the identification constant 16'hB5E1.
- R3: In a control word, bit 15 selects read-only mode when 1. Bits 14:8 hold the starting register offset and bits 7:0 hold the word count. The first data word after the control word accesses the register at that offset.
- R4: In read-only mode, MOSI data is ignored, no write strobe is issued and register contents stay unchanged.
- R5: In read-write mode, each data word returns the addressed register's prior content on MISO. It also produces exactly one write of the received word to that same address.
- R6: The captured control word remains in effect for later words and bursts until the next re-arm.
- R7: The register address increases by one per data word, modulo 128. After the counted number of words, the next word starts again at the offset.
- R8: A word count of zero is treated as 256 words: the address keeps advancing and does not restart after one word.
- R9: SPI mode 1 is used. MOSI is sampled on SCLK falling edges and bits travel MSB first. Each word's MSB is on MISO before that word's first SCLK edge.
- R10: The write strobe is a single system-clock pulse, raised only after all 16 bits of a data word have been received.
- R11: When a write targets the address that the following word reads, that following word returns the newly written value.
- R12: A re-arm in the middle of a word discards the partial bits, so the next full word is a control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCLK |
| rst_i | input | 1 | Global reset, active high, synchronous to clk_i |
| rearm_i | input | 1 | Control-reset; a pulse makes the next word a control word |
| sclk_i | input | 1 | SPI clock from master, idles low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| rd_addr_o | output | 7 | Register read address |
| rd_data_i | input | 16 | Register read data for rd_addr_o (combinational) |
| wr_en_o | output | 1 | Single-cycle register write strobe |
| wr_addr_o | output | 7 | Register write address |
| wr_data_o | output | 16 | Register write data |

## Verification
Two events can fall on the same register in back-to-back cycles: the write-back of a finished read-write word, and the preload of the next word's MISO data from the register bank. This happens whenever the window wraps onto the address just written. The bench provokes it with a one-word read-write window sent three times, and with a two-word window that straddles address 127 and address 0. It judges each following word by comparing its returned MISO value with the data the bench itself sent in the previous word.

// File: rtl/spi_regwin_pkg.sv
package spi_regwin_pkg;
   typedef enum logic {
      PH_CTL  = 1'b0,
      PH_DATA = 1'b1
   } phase_e;

   localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/spi_regwin_sync.sv
module spi_regwin_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned NBITS  = 3
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [NBITS-1:0] async_i,
   output logic [NBITS-1:0] sync_o,
   output logic             fall0_o
);
   logic [NBITS-1:0] stage_q [STAGES];
   logic             prev0_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) stage_q[g] <= '0;
            else       stage_q[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) stage_q[g] <= '0;
            else       stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) prev0_q <= 1'b0;
      else       prev0_q <= stage_q[STAGES-1][0];
   end

   assign sync_o  = stage_q[STAGES-1];
   assign fall0_o = prev0_q & ~stage_q[STAGES-1][0];
endmodule

// File: rtl/spi_regwin_shifter.sv
module spi_regwin_shifter #(
   parameter int unsigned       WORD_W  = 16,
   parameter logic [WORD_W-1:0] ID_WORD = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              clear_i,
   input  logic              sample_i,
   input  logic              mosi_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_data_i,
   output logic              miso_o,
   output logic              word_done_o,
   output logic [WORD_W-1:0] rx_word_o
);
   localparam int unsigned BCW  = $clog2(WORD_W);
   localparam logic [BCW-1:0] LAST = BCW'(WORD_W - 1);

   logic [BCW-1:0]    bit_q;
   logic [WORD_W-1:0] in_q;
   logic [WORD_W-1:0] out_q;

   always_ff @(posedge clk_i) begin
      word_done_o <= 1'b0;
      if (rst_i || clear_i) begin
         bit_q     <= '0;
         in_q      <= '0;
         out_q     <= ID_WORD;
         rx_word_o <= '0;
      end else begin
         if (load_i)        out_q <= load_data_i;
         else if (sample_i) out_q <= {out_q[WORD_W-2:0], 1'b0};
         if (sample_i) begin
            in_q <= {in_q[WORD_W-2:0], mosi_i};
            if (bit_q == LAST) begin
               bit_q       <= '0;
               word_done_o <= 1'b1;
               rx_word_o   <= {in_q[WORD_W-2:0], mosi_i};
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   assign miso_o = out_q[WORD_W-1];
endmodule

// File: rtl/spi_regwin_seq.sv
module spi_regwin_seq
   import spi_regwin_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned OFS_W    = 7,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned LOAD_LAT = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              clear_i,
   input  logic              word_done_i,
   input  logic [WORD_W-1:0] rx_word_i,
   output logic              load_o,
   output logic [OFS_W-1:0]  rd_addr_o,
   output logic              wr_en_o,
   output logic [OFS_W-1:0]  wr_addr_o,
   output logic [WORD_W-1:0] wr_data_o
);
   localparam logic [CNT_W:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};

   phase_e             phase_q;
   logic               rd_only_q;
   logic [OFS_W-1:0]   ofs_q;
   logic [OFS_W-1:0]   addr_q;
   logic [CNT_W:0]     span_q;
   logic [CNT_W:0]     left_q;
   logic [LOAD_LAT-1:0] pend_q;

   logic               ctl_rd;
   logic [OFS_W-1:0]   ctl_ofs;
   logic [CNT_W-1:0]   ctl_cnt;
   logic [CNT_W:0]     ctl_span;
   logic               at_end;

   assign ctl_rd   = rx_word_i[WORD_W-1];
   assign ctl_ofs  = rx_word_i[WORD_W-2 -: OFS_W];
   assign ctl_cnt  = rx_word_i[CNT_W-1:0];
   assign ctl_span = (ctl_cnt == '0) ? FULL_SPAN : {1'b0, ctl_cnt};
   assign at_end   = (left_q == {{CNT_W{1'b0}}, 1'b1});

   always_ff @(posedge clk_i) begin
      wr_en_o <= 1'b0;
      if (rst_i) begin
         phase_q   <= PH_CTL;
         rd_only_q <= 1'b1;
         ofs_q     <= '0;
         addr_q    <= '0;
         span_q    <= FULL_SPAN;
         left_q    <= FULL_SPAN;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else if (clear_i) begin
         phase_q <= PH_CTL;
      end else if (word_done_i) begin
         if (phase_q == PH_CTL) begin
            phase_q   <= PH_DATA;
            rd_only_q <= ctl_rd;
            ofs_q     <= ctl_ofs;
            addr_q    <= ctl_ofs;
            span_q    <= ctl_span;
            left_q    <= ctl_span;
         end else begin
            if (!rd_only_q) begin
               wr_en_o   <= 1'b1;
               wr_addr_o <= addr_q;
               wr_data_o <= rx_word_i;
            end
            if (at_end) begin
               addr_q <= ofs_q;
               left_q <= span_q;
            end else begin
               addr_q <= addr_q + 1'b1;
               left_q <= left_q - 1'b1;
            end
         end
      end
   end

   if (LOAD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk_i) begin
         if (rst_i || clear_i) pend_q <= '0;
         else                  pend_q <= word_done_i;
      end
   end else begin : g_latn
      always_ff @(posedge clk_i) begin
         if (rst_i || clear_i) pend_q <= '0;
         else                  pend_q <= {pend_q[LOAD_LAT-2:0], word_done_i};
      end
   end

   assign load_o    = pend_q[LOAD_LAT-1];
   assign rd_addr_o = addr_q;
endmodule

// File: rtl/spi_regwin_slave.sv
module spi_regwin_slave
   import spi_regwin_pkg::*;
#(
   parameter int unsigned       WORD_W      = 16,
   parameter int unsigned       OFS_W       = 7,
   parameter int unsigned       CNT_W       = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       LOAD_LAT    = 2,
   parameter logic [WORD_W-1:0] ID_WORD     = 16'hB5E1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              rearm_i,
   input  logic              sclk_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic [OFS_W-1:0]  rd_addr_o,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [OFS_W-1:0]  wr_addr_o,
   output logic [WORD_W-1:0] wr_data_o
);
   localparam int unsigned NSYNC = 3;

   if (WORD_W != 1 + OFS_W + CNT_W) begin : g_bad_layout
      $error("control word layout does not fill WORD_W");
   end
   if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
      $error("SYNC_STAGES below minimum");
   end
   if (LOAD_LAT < 2) begin : g_bad_lat
      $error("LOAD_LAT must be at least 2 for write-then-read ordering");
   end

   logic [NSYNC-1:0]  sync_v;
   logic              sclk_fall;
   logic              mosi_s;
   logic              rearm_s;
   logic              word_done;
   logic [WORD_W-1:0] rx_word;
   logic              load;

   spi_regwin_sync #(
      .STAGES (SYNC_STAGES),
      .NBITS  (NSYNC)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i ({rearm_i, mosi_i, sclk_i}),
      .sync_o  (sync_v),
      .fall0_o (sclk_fall)
   );

   assign mosi_s  = sync_v[1];
   assign rearm_s = sync_v[2];

   spi_regwin_shifter #(
      .WORD_W  (WORD_W),
      .ID_WORD (ID_WORD)
   ) u_shift (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .clear_i     (rearm_s),
      .sample_i    (sclk_fall),
      .mosi_i      (mosi_s),
      .load_i      (load),
      .load_data_i (rd_data_i),
      .miso_o      (miso_o),
      .word_done_o (word_done),
      .rx_word_o   (rx_word)
   );

   spi_regwin_seq #(
      .WORD_W   (WORD_W),
      .OFS_W    (OFS_W),
      .CNT_W    (CNT_W),
      .LOAD_LAT (LOAD_LAT)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .clear_i     (rearm_s),
      .word_done_i (word_done),
      .rx_word_i   (rx_word),
      .load_o      (load),
      .rd_addr_o   (rd_addr_o),
      .wr_en_o     (wr_en_o),
      .wr_addr_o   (wr_addr_o),
      .wr_data_o   (wr_data_o)
   );
endmodule

// File: rtl/spi_regwin_chk.sv
module spi_regwin_chk #(
   parameter int unsigned       WORD_W  = 16,
   parameter int unsigned       OFS_W   = 7,
   parameter logic [WORD_W-1:0] ID_WORD = 16'hB5E1
) (
   input logic             clk,
   input logic             rst,
   input logic             rearm_s,
   input logic             word_done,
   input logic             wr_en,
   input logic             miso,
   input logic [OFS_W-1:0] rd_addr
);
   AST_RST_STATE: assert property (@(posedge clk)
      rst |=> (miso == ID_WORD[WORD_W-1]) && !wr_en); // R1

   AST_REARM_ID: assert property (@(posedge clk) disable iff (rst)
      rearm_s |=> (miso == ID_WORD[WORD_W-1])); // R2

   AST_WR_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> $past(word_done)); // R10

   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en); // R10

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(word_done) |-> $stable(rd_addr)); // R7
endmodule

bind spi_regwin_slave spi_regwin_chk #(
   .WORD_W  (WORD_W),
   .OFS_W   (OFS_W),
   .ID_WORD (ID_WORD)
) u_chk (
   .clk       (clk_i),
   .rst       (rst_i),
   .rearm_s   (rearm_s),
   .word_done (word_done),
   .wr_en     (wr_en_o),
   .miso      (miso_o),
   .rd_addr   (rd_addr_o)
);

// File: tb/tb_spi_regwin_slave.sv
`timescale 1ns/1ps
module tb_spi_regwin_slave;
   localparam int HALF = 6;
   localparam int GAP  = 12;
   localparam logic [15:0] ID = 16'hB5E1;
   localparam int NV = 6;
   localparam logic [15:0] VCTL [NV] = '{16'h8A04, 16'h1303, 16'h7F02, 16'h8001, 16'h0501, 16'h8500};
   localparam int          VN   [NV] = '{6, 5, 3, 2, 3, 4};

   logic clk = 1'b0, rst = 1'b1, rearm = 1'b0, sclk = 1'b0, mosi = 1'b0;
   logic miso, wr_en;
   logic [6:0]  rd_addr, wr_addr;
   logic [15:0] rd_data, wr_data;
   logic [15:0] bank [128];
   logic [15:0] expb [128];
   int nchk = 0, nfail = 0, wr_cnt = 0, long_cnt = 0;
   logic prev_wr = 1'b0;

   logic m_rd;
   logic [6:0] m_ofs, m_addr;
   int m_span, m_left;

   always #2.5 clk = ~clk;

   spi_regwin_slave dut (
      .clk_i(clk), .rst_i(rst), .rearm_i(rearm), .sclk_i(sclk), .mosi_i(mosi),
      .miso_o(miso), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   assign rd_data = bank[rd_addr];

   always @(posedge clk) begin
      if (wr_en) begin
         bank[wr_addr] <= wr_data;
         wr_cnt <= wr_cnt + 1;
      end
      if (wr_en && prev_wr) long_cnt <= long_cnt + 1;
      prev_wr <= wr_en;
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer_bits(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
      rx = '0;
      for (int i = 15; i > 15 - nbits; i--) begin
         @(negedge clk); mosi = tx[i]; sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0; rx[i] = miso;   // R9 sample at falling edge
         repeat (HALF - 1) @(negedge clk);
      end
      repeat (GAP) @(negedge clk);
   endtask

   task automatic pulse_rearm();
      @(negedge clk); rearm = 1'b1;
      repeat (4) @(negedge clk); rearm = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic set_ctl(input logic [15:0] c);
      m_rd = c[15]; m_ofs = c[14:8]; m_addr = c[14:8];
      m_span = (c[7:0] == 8'd0) ? 256 : int'(c[7:0]);
      m_left = m_span;
   endtask

   task automatic data_word(input logic [15:0] tx, input string req);
      logic [15:0] rx, e;
      e = expb[m_addr];
      xfer_bits(tx, 16, rx);
      chk(req, rx, e);
      if (!m_rd) expb[m_addr] = tx;
      if (m_left == 1) begin m_addr = m_ofs; m_left = m_span; end
      else begin m_addr = m_addr + 7'd1; m_left--; end
   endtask

   task automatic ctl_word(input logic [15:0] c, input string req);
      logic [15:0] rx;
      xfer_bits(c, 16, rx);
      chk(req, rx, ID);
      set_ctl(c);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [15:0] rx;
      int w0;
      for (int a = 0; a < 128; a++) begin
         bank[a] = 16'h3000 + 16'(a * 16'h0107);
         expb[a] = 16'h3000 + 16'(a * 16'h0107);
      end
      repeat (6) @(negedge clk);
      rst = 1'b0;
      repeat (6) @(negedge clk);

      // R1 reset state and default control phase
      chk("R1 miso after reset", {15'd0, miso}, {15'd0, ID[15]});
      chk("R1 no strobe after reset", {15'd0, wr_en}, 16'd0);
      ctl_word(16'h8301, "R1 first word is control");
      data_word(16'hFFFF, "R1 R3 first data word");

      // vector table
      for (int v = 0; v < NV; v++) begin
         w0 = wr_cnt;
         pulse_rearm();
         ctl_word(VCTL[v], "R2 control word returns id");
         for (int k = 0; k < VN[v]; k++)
            data_word(16'hC000 ^ 16'(v << 8) ^ 16'(k * 16'h0011),
                      "R3 R5 R7 R8 R9 R11 data word");
         chk(VCTL[v][15] ? "R4 no writes in read-only" : "R5 one write per word",
             16'(wr_cnt - w0), VCTL[v][15] ? 16'd0 : 16'(VN[v]));
      end

      // R6 persistence across bursts without re-arm
      data_word(16'h1234, "R6 reuse control word");
      data_word(16'h5678, "R6 reuse control word");

      // R4 read back previously read-only window
      pulse_rearm();
      ctl_word(16'h8A04, "R2 control word returns id");
      for (int k = 0; k < 4; k++) data_word(16'hAAAA, "R4 contents unchanged");

      // R12 re-arm mid word
      pulse_rearm();
      xfer_bits(16'h0F0F, 7, rx);
      pulse_rearm();
      ctl_word(16'h9003, "R12 partial word discarded");
      data_word(16'h0000, "R12 data after re-arm");
      data_word(16'h0000, "R12 data after re-arm");

      // R10 strobe width
      chk("R10 single cycle strobe", 16'(long_cnt), 16'd0);

      // R1 global reset mid burst
      pulse_rearm();
      ctl_word(16'h2002, "R2 control word returns id");
      data_word(16'h4321, "R5 write before reset");
      @(negedge clk); rst = 1'b1;
      repeat (10) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 miso after mid-burst reset", {15'd0, miso}, {15'd0, ID[15]});
      chk("R1 no strobe after mid-burst reset", {15'd0, wr_en}, 16'd0);
      ctl_word(16'hA002, "R1 control phase after reset");
      data_word(16'h0000, "R1 R5 read back after reset");
      data_word(16'h0000, "R1 R7 read back after reset");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule